// File: doc/BRIEF.md
# Interval Double-Precision Multiplier

This block multiplies two closed intervals X = [xl, xu] and Y = [yl, yu]. Every endpoint is a binary floating-point word with a sign bit, a biased exponent field and a fraction field. The result is an interval Z = [zl, zu] that encloses every product x*y with x in X and y in Y. The sign bits of each interval put it in one of three classes. The pair of classes then steers two operand multiplexers that feed a lower-bound datapath and an upper-bound datapath. The lower datapath rounds toward minus infinity and the upper datapath rounds toward plus infinity, so the enclosure is never lost to rounding.

When both intervals straddle zero, each bound is a choice between two candidate products. The two datapaths then run twice in a row, and an extra cycle picks the minimum and the maximum. Otherwise one pass produces both bounds directly. Operands are taken on a valid/ready handshake into input registers. Results appear in output registers with a one-cycle valid pulse. Exponent overflow and underflow saturate the result and raise sticky flags.

Top module: `interval_fmul`

## Requirements
- R1: `in_ready_o` is high only while the block is idle. An operand set is taken on a rising clock edge with `in_valid_i` and `in_ready_o` both high. `in_ready_o` stays low from that edge until the result has been written.
- R2: `out_valid_o` is a one-cycle pulse. When the operands do not both straddle zero, the pulse appears one cycle after the accepting edge.
- R3: Classification per interval uses bit W-1 (the sign). A clear sign on the lower endpoint means positive. Otherwise a set sign on the upper endpoint means negative. Any other combination means straddling. zl is the least and zu the greatest of the four cross products xl*yl, xl*yu, xu*yl and xu*yu.
- R4: When both intervals straddle zero, zl = min(xl*yu, xu*yl) and zu = max(xl*yl, xu*yu), and `out_valid_o` pulses three cycles after the accepting edge.
- R5: Each endpoint product follows the same rules. Its sign (bit W-1) is the XOR of the operand signs. Its exponent field (bits W-2 down to FRAC_W) is the sum of the operand exponent fields minus the bias 2^(EXP_W-1)-1. The significands include the hidden 1. A product significand of 2 or more is shifted right by one, and the exponent is incremented.
- R6: An inexact lower bound is rounded toward minus infinity and an inexact upper bound toward plus infinity. For a point interval squared with an inexact product, zu is exactly one unit in the last place above zl. An exact product gives zl = zu.
- R7: An operand whose exponent field is zero counts as zero. The product is then a zero with sign equal to the XOR of the operand signs, and no flag changes.
- R8: A biased result exponent of 2^EXP_W - 1 or more produces infinity with the product sign and sets `ovf_o`. `ovf_o` stays set until reset.
- R9: A biased result exponent of zero or less produces a zero with the product sign and sets `unf_o`. `unf_o` stays set until reset.
- R10: After reset, `in_ready_o` is 1, and `out_valid_o`, `ovf_o`, `unf_o`, `zl_o` and `zu_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set offered |
| in_ready_o | output | 1 | Block idle, can take operands |
| xl_i | input | W | Lower endpoint of X |
| xu_i | input | W | Upper endpoint of X |
| yl_i | input | W | Lower endpoint of Y |
| yu_i | input | W | Upper endpoint of Y |
| out_valid_o | output | 1 | Result pulse |
| zl_o | output | W | Lower bound of the product interval |
| zu_o | output | W | Upper bound of the product interval |
| ovf_o | output | 1 | Sticky exponent overflow |
| unf_o | output | 1 | Sticky exponent underflow |

W = 1 + EXP_W + FRAC_W, which is 64 by default.

## Verification
All nine pairings of the three interval classes are swept. Each pairing is tried with several magnitude sets, some with exact and some with inexact significands. The expected bounds are the minimum and the maximum of four directed-rounded reference products, chosen by numeric comparison and not by the selection table, so a wrong operand route in any single case shows up. In the case where both intervals straddle zero, the magnitudes vary which candidate wins, and that exposes a swapped or missing compare. Separate patterns cover a point interval with an inexact square (rounding direction), a zero endpoint (signed zero), and very large and very small operands (saturation and sticky flags).

// File: rtl/interval_fmul_pkg.sv
package interval_fmul_pkg;

  typedef enum logic [1:0] {
    CLS_POS = 2'd0,
    CLS_NEG = 2'd1,
    CLS_MIX = 2'd2
  } iv_class_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ONE  = 3'd1,
    ST_PH0  = 3'd2,
    ST_PH1  = 3'd3,
    ST_PH2  = 3'd4
  } iv_state_e;

  // endpoint pick: 0 selects the lower endpoint, 1 the upper
  typedef struct packed {
    logic hi_x;
    logic hi_y;
  } iv_pick_t;

endpackage

// File: rtl/interval_fmul_class.sv
module interval_fmul_class
  import interval_fmul_pkg::*;
(
  input  logic      lo_sign_i,
  input  logic      hi_sign_i,
  output iv_class_e cls_o
);

  always_comb begin
    if (!lo_sign_i)     cls_o = CLS_POS;
    else if (hi_sign_i) cls_o = CLS_NEG;
    else                cls_o = CLS_MIX;
  end

endmodule

// File: rtl/interval_fmul_sel.sv
module interval_fmul_sel
  import interval_fmul_pkg::*;
(
  input  iv_class_e cx_i,
  input  iv_class_e cy_i,
  input  logic      phase_i,
  output iv_pick_t  lo_pick_o,
  output iv_pick_t  hi_pick_o
);

  always_comb begin
    lo_pick_o = 2'b00;
    hi_pick_o = 2'b00;
    case ({cx_i, cy_i})
      {CLS_POS, CLS_POS}: begin lo_pick_o = 2'b00; hi_pick_o = 2'b11; end
      {CLS_NEG, CLS_NEG}: begin lo_pick_o = 2'b11; hi_pick_o = 2'b00; end
      {CLS_POS, CLS_NEG}: begin lo_pick_o = 2'b10; hi_pick_o = 2'b01; end
      {CLS_NEG, CLS_POS}: begin lo_pick_o = 2'b01; hi_pick_o = 2'b10; end
      {CLS_MIX, CLS_POS}: begin lo_pick_o = 2'b01; hi_pick_o = 2'b11; end
      {CLS_POS, CLS_MIX}: begin lo_pick_o = 2'b10; hi_pick_o = 2'b11; end
      {CLS_MIX, CLS_NEG}: begin lo_pick_o = 2'b10; hi_pick_o = 2'b00; end
      {CLS_NEG, CLS_MIX}: begin lo_pick_o = 2'b01; hi_pick_o = 2'b00; end
      {CLS_MIX, CLS_MIX}: begin
        // phase 0: xl*yu / xl*yl, phase 1: xu*yl / xu*yu
        lo_pick_o = phase_i ? 2'b10 : 2'b01;
        hi_pick_o = phase_i ? 2'b11 : 2'b00;
      end
      default: begin lo_pick_o = 2'b00; hi_pick_o = 2'b00; end
    endcase
  end

endmodule

// File: rtl/interval_fmul_mul.sv
module interval_fmul_mul #(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter bit ROUND_UP = 1'b0
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  output logic [EXP_W+FRAC_W:0] p_o,
  output logic                  ovf_o,
  output logic                  unf_o
);

  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int P  = FRAC_W + 1;
  localparam int EW = EXP_W + 2;
  localparam logic signed [EW-1:0] BIAS  = EW'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [EW-1:0] EMAX  = EW'((1 << EXP_W) - 1);
  localparam logic signed [EW-1:0] EZERO = '0;

  logic                   sgn, zero_in, inexact, bump;
  logic [EXP_W-1:0]       ea, eb;
  logic [P-1:0]           ma, mb, mant;
  logic [2*P-1:0]         prod, norm;
  logic [P:0]             mant_r;
  logic signed [EW-1:0]   e_sum;

  always_comb begin
    sgn     = a_i[W-1] ^ b_i[W-1];
    ea      = a_i[W-2 -: EXP_W];
    eb      = b_i[W-2 -: EXP_W];
    zero_in = (ea == '0) || (eb == '0);
    ma      = {1'b1, a_i[FRAC_W-1:0]};
    mb      = {1'b1, b_i[FRAC_W-1:0]};
    prod    = {{P{1'b0}}, ma} * {{P{1'b0}}, mb};
    norm    = prod[2*P-1] ? prod : (prod << 1);
    mant    = norm[2*P-1 -: P];
    inexact = |norm[P-1:0];
    // away from zero when the rounding direction points away
    bump    = inexact && (sgn != ROUND_UP);
    mant_r  = {1'b0, mant} + (P+1)'(bump);
    e_sum   = EW'(ea) + EW'(eb) - BIAS + EW'(prod[2*P-1]) + EW'(mant_r[P]);

    ovf_o = 1'b0;
    unf_o = 1'b0;
    if (zero_in) begin
      p_o = {sgn, {(W-1){1'b0}}};
    end else if (e_sum >= EMAX) begin
      p_o   = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_o = 1'b1;
    end else if (e_sum <= EZERO) begin
      p_o   = {sgn, {(W-1){1'b0}}};
      unf_o = 1'b1;
    end else begin
      p_o = {sgn, e_sum[EXP_W-1:0], mant_r[FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/interval_fmul.sv
module interval_fmul
  import interval_fmul_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [EXP_W+FRAC_W:0] xl_i,
  input  logic [EXP_W+FRAC_W:0] xu_i,
  input  logic [EXP_W+FRAC_W:0] yl_i,
  input  logic [EXP_W+FRAC_W:0] yu_i,
  output logic                  out_valid_o,
  output logic [EXP_W+FRAC_W:0] zl_o,
  output logic [EXP_W+FRAC_W:0] zu_o,
  output logic                  ovf_o,
  output logic                  unf_o
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int LANES = 2;  // lane 0 lower bound, lane 1 upper bound

  function automatic logic fp_less(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] ka, kb;
    ka = a[W-1] ? ~a : (a | {1'b1, {(W-1){1'b0}}});
    kb = b[W-1] ? ~b : (b | {1'b1, {(W-1){1'b0}}});
    return ka < kb;
  endfunction

  iv_state_e  st_q;
  iv_class_e  cx_d, cy_d, cx_q, cy_q;
  logic [W-1:0] xl_q, xu_q, yl_q, yu_q;
  logic [W-1:0] hold_lo_q, hold_hi_q, alt_lo_q, alt_hi_q;
  logic [W-1:0] zl_q, zu_q;
  logic         vld_q, ovf_q, unf_q;

  logic         accept, computing;
  iv_pick_t     pick [LANES];
  logic [W-1:0] op_a [LANES];
  logic [W-1:0] op_b [LANES];
  logic [W-1:0] prod [LANES];
  logic         p_ovf [LANES];
  logic         p_unf [LANES];

  assign in_ready_o  = (st_q == ST_IDLE);
  assign accept      = in_valid_i && in_ready_o;
  assign computing   = (st_q == ST_ONE) || (st_q == ST_PH0) || (st_q == ST_PH1);
  assign out_valid_o = vld_q;
  assign zl_o        = zl_q;
  assign zu_o        = zu_q;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;

  interval_fmul_class u_cls_x (.lo_sign_i(xl_i[W-1]), .hi_sign_i(xu_i[W-1]), .cls_o(cx_d));
  interval_fmul_class u_cls_y (.lo_sign_i(yl_i[W-1]), .hi_sign_i(yu_i[W-1]), .cls_o(cy_d));

  interval_fmul_sel u_sel (
    .cx_i     (cx_q),
    .cy_i     (cy_q),
    .phase_i  (st_q == ST_PH1),
    .lo_pick_o(pick[0]),
    .hi_pick_o(pick[1])
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign op_a[g] = pick[g].hi_x ? xu_q : xl_q;
    assign op_b[g] = pick[g].hi_y ? yu_q : yl_q;

    interval_fmul_mul #(
      .EXP_W   (EXP_W),
      .FRAC_W  (FRAC_W),
      .ROUND_UP(1'(g))
    ) u_mul (
      .a_i  (op_a[g]),
      .b_i  (op_b[g]),
      .p_o  (prod[g]),
      .ovf_o(p_ovf[g]),
      .unf_o(p_unf[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cx_q      <= CLS_POS;
      cy_q      <= CLS_POS;
      xl_q      <= '0;
      xu_q      <= '0;
      yl_q      <= '0;
      yu_q      <= '0;
      hold_lo_q <= '0;
      hold_hi_q <= '0;
      alt_lo_q  <= '0;
      alt_hi_q  <= '0;
      zl_q      <= '0;
      zu_q      <= '0;
      vld_q     <= 1'b0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (computing && (p_ovf[0] || p_ovf[1])) ovf_q <= 1'b1;
      if (computing && (p_unf[0] || p_unf[1])) unf_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            xl_q <= xl_i;
            xu_q <= xu_i;
            yl_q <= yl_i;
            yu_q <= yu_i;
            cx_q <= cx_d;
            cy_q <= cy_d;
            st_q <= (cx_d == CLS_MIX && cy_d == CLS_MIX) ? ST_PH0 : ST_ONE;
          end
        end
        ST_ONE: begin
          zl_q  <= prod[0];
          zu_q  <= prod[1];
          vld_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        ST_PH0: begin
          hold_lo_q <= prod[0];
          hold_hi_q <= prod[1];
          st_q      <= ST_PH1;
        end
        ST_PH1: begin
          alt_lo_q <= prod[0];
          alt_hi_q <= prod[1];
          st_q     <= ST_PH2;
        end
        ST_PH2: begin
          zl_q  <= fp_less(alt_lo_q, hold_lo_q) ? alt_lo_q : hold_lo_q;
          zu_q  <= fp_less(hold_hi_q, alt_hi_q) ? alt_hi_q : hold_hi_q;
          vld_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/interval_fmul_chk.sv
module interval_fmul_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic                  in_ready_o,
  input logic                  xl_sign_i,
  input logic                  xu_sign_i,
  input logic                  yl_sign_i,
  input logic                  yu_sign_i,
  input logic                  out_valid_o,
  input logic [EXP_W+FRAC_W:0] zl_o,
  input logic [EXP_W+FRAC_W:0] zu_o,
  input logic                  ovf_o,
  input logic                  unf_o
);

  localparam int W = 1 + EXP_W + FRAC_W;

  function automatic logic key_less(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] ka, kb;
    ka = a[W-1] ? ~a : (a | {1'b1, {(W-1){1'b0}}});
    kb = b[W-1] ? ~b : (b | {1'b1, {(W-1){1'b0}}});
    return ka < kb;
  endfunction

  logic take, both_mix;
  assign take     = in_valid_i && in_ready_o;
  assign both_mix = xl_sign_i && !xu_sign_i && yl_sign_i && !yu_sign_i;

  assert_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !in_ready_o);

  assert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_lat_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !both_mix) |=> ##1 out_valid_o);

  assert_lat_mix_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && both_mix) |=> ##3 out_valid_o);

  assert_mix_early_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && both_mix) |=> ##1 !out_valid_o);

  assert_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !key_less(zu_o, zl_o));

  assert_sticky_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  assert_sticky_unf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);

endmodule

bind interval_fmul interval_fmul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .xl_sign_i  (xl_i[EXP_W+FRAC_W]),
  .xu_sign_i  (xu_i[EXP_W+FRAC_W]),
  .yl_sign_i  (yl_i[EXP_W+FRAC_W]),
  .yu_sign_i  (yu_i[EXP_W+FRAC_W]),
  .out_valid_o(out_valid_o),
  .zl_o       (zl_o),
  .zu_o       (zu_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/sim_interval_fmul.sv
`timescale 1ns/1ps
module sim_interval_fmul;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready, out_valid, ovf, unf;
  logic [63:0] xl = '0, xu = '0, yl = '0, yu = '0;
  logic [63:0] zl, zu;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] got_zl, got_zu;
  int          got_lat;

  always #10 clk = ~clk;  // 50 MHz

  interval_fmul u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .xl_i(xl), .xu_i(xu), .yl_i(yl), .yu_i(yu),
    .out_valid_o(out_valid), .zl_o(zl), .zu_o(zu), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit same_val(logic [63:0] a, logic [63:0] b);
    return (a == b) || (a[62:0] == '0 && b[62:0] == '0);
  endfunction

  // directed-rounding reference product: up=1 rounds toward +inf, up=0 toward -inf
  function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b,
                                          input bit up);
    bit           s, inx;
    int           e;
    logic [105:0] p;
    logic [52:0]  m;
    logic [53:0]  mr;
    s = a[63] ^ b[63];
    if (a[62:52] == 0 || b[62:52] == 0) return {s, 63'b0};
    p = {53'b0, 1'b1, a[51:0]} * {53'b0, 1'b1, b[51:0]};
    e = int'(a[62:52]) + int'(b[62:52]) - 1023;
    if (p[105]) begin m = p[105:53]; inx = |p[52:0]; e = e + 1; end
    else        begin m = p[104:52]; inx = |p[51:0]; end
    mr = {1'b0, m} + ((inx && (s ? !up : up)) ? 54'd1 : 54'd0);
    if (mr[53]) begin e = e + 1; mr = mr >> 1; end
    if (e >= 2047) return {s, 11'h7ff, 52'b0};
    if (e <= 0)    return {s, 63'b0};
    return {s, e[10:0], mr[51:0]};
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, input logic [63:0] d);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready when idle", {63'b0, in_ready}, 64'd1);
    xl = a; xu = b; yl = c; yu = d;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R1", "busy after accept", {63'b0, in_ready}, 64'd0);
    got_lat = 0;
    while (!out_valid && got_lat < 10) begin
      @(posedge clk);
      @(negedge clk);
      got_lat++;
    end
    got_zl = zl;
    got_zu = zu;
  endtask

  // one interval in class cls (0 pos, 1 neg, 2 straddle) from magnitudes m1, m2
  task automatic mk(input int cls, input real m1, input real m2,
                    output logic [63:0] lo, output logic [63:0] hi);
    real s, b;
    s = (m1 < m2) ? m1 : m2;
    b = (m1 < m2) ? m2 : m1;
    case (cls)
      0:       begin lo = $realtobits(s);   hi = $realtobits(b);  end
      1:       begin lo = $realtobits(-b);  hi = $realtobits(-s); end
      default: begin lo = $realtobits(-m1); hi = $realtobits(m2); end
    endcase
  endtask

  task automatic check_bounds(input logic [63:0] a, input logic [63:0] b,
                              input logic [63:0] c, input logic [63:0] d, input string req);
    logic [63:0] dn [4];
    logic [63:0] upv [4];
    logic [63:0] ez, eu;
    dn[0] = ref_mul(a, c, 1'b0); upv[0] = ref_mul(a, c, 1'b1);
    dn[1] = ref_mul(a, d, 1'b0); upv[1] = ref_mul(a, d, 1'b1);
    dn[2] = ref_mul(b, c, 1'b0); upv[2] = ref_mul(b, c, 1'b1);
    dn[3] = ref_mul(b, d, 1'b0); upv[3] = ref_mul(b, d, 1'b1);
    ez = dn[0];
    eu = upv[0];
    for (int i = 1; i < 4; i++) begin
      if ($bitstoreal(dn[i]) < $bitstoreal(ez))  ez = dn[i];
      if ($bitstoreal(upv[i]) > $bitstoreal(eu)) eu = upv[i];
    end
    chk(same_val(got_zl, ez), req, "lower bound", got_zl, ez);
    chk(same_val(got_zu, eu), req, "upper bound", got_zu, eu);
  endtask

  real mags [6] = '{1.0, 1.5, 1.1, 3.0, 0.3, 7.25};

  initial begin
    logic [63:0] a, b, c, d;
    int exp_lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(in_ready == 1'b1,  "R10", "ready",     {63'b0, in_ready}, 64'd1);
    chk(out_valid == 1'b0, "R10", "out_valid", {63'b0, out_valid}, 64'd0);
    chk(ovf == 1'b0 && unf == 1'b0, "R10", "flags", {62'b0, ovf, unf}, 64'd0);
    chk(zl == '0 && zu == '0, "R10", "bounds", zl | zu, 64'd0);

    // R3 R4 sweep over all class pairs and magnitude sets
    for (int cx = 0; cx < 3; cx++) begin
      for (int cy = 0; cy < 3; cy++) begin
        for (int i = 0; i < 6; i++) begin
          mk(cx, mags[i], mags[(i + 1) % 6], a, b);
          mk(cy, mags[(i + 3) % 6], mags[(i + 4) % 6], c, d);
          run_op(a, b, c, d);
          exp_lat = (cx == 2 && cy == 2) ? 3 : 1;
          chk(got_lat == exp_lat, (exp_lat == 3) ? "R4" : "R2", "latency",
              64'(got_lat), 64'(exp_lat));
          check_bounds(a, b, c, d, (exp_lat == 3) ? "R4" : "R3");
          @(negedge clk);
          chk(out_valid == 1'b0, "R2", "single pulse", {63'b0, out_valid}, 64'd0);
        end
      end
    end

    // R6 inexact point square: upper is one ulp above lower
    a = $realtobits(1.1);
    run_op(a, a, a, a);
    chk(got_zu == got_zl + 64'd1, "R6", "ulp gap", got_zu, got_zl + 64'd1);
    chk(got_zl == ref_mul(a, a, 1'b0), "R6", "round down", got_zl, ref_mul(a, a, 1'b0));

    // R5 exact product 1.5*2.0 = 3.0, both bounds equal
    run_op($realtobits(1.5), $realtobits(1.5), $realtobits(2.0), $realtobits(2.0));
    chk(got_zl == 64'h4008000000000000, "R5", "exact lower", got_zl, 64'h4008000000000000);
    chk(got_zu == 64'h4008000000000000, "R5", "exact upper", got_zu, 64'h4008000000000000);
    // R5 normalisation shift: 1.5*1.5 = 2.25
    run_op($realtobits(-1.5), $realtobits(-1.5), $realtobits(1.5), $realtobits(1.5));
    chk(got_zl == $realtobits(-2.25), "R5", "normalised", got_zl, $realtobits(-2.25));

    // R7 zero endpoint gives signed zero, flags untouched
    run_op(64'h0, 64'h0, $realtobits(-3.0), $realtobits(-2.0));
    chk(got_zl == 64'h8000000000000000, "R7", "signed zero lower", got_zl, 64'h8000000000000000);
    chk(got_zu == 64'h8000000000000000, "R7", "signed zero upper", got_zu, 64'h8000000000000000);
    chk(ovf == 1'b0 && unf == 1'b0, "R7", "no flags", {62'b0, ovf, unf}, 64'd0);

    // R9 underflow flushes and sets sticky flag
    a = $realtobits(1.0e-200);
    run_op(a, a, a, a);
    chk(got_zl == 64'h0 && got_zu == 64'h0, "R9", "flush to zero", got_zl | got_zu, 64'h0);
    chk(unf == 1'b1 && ovf == 1'b0, "R9", "unf flag", {62'b0, ovf, unf}, 64'd1);

    // R8 overflow saturates and sets sticky flag
    a = $realtobits(1.0e200);
    run_op(a, a, a, a);
    chk(got_zu == 64'h7ff0000000000000, "R8", "+inf", got_zu, 64'h7ff0000000000000);
    chk(ovf == 1'b1, "R8", "ovf flag", {63'b0, ovf}, 64'd1);
    run_op($realtobits(-1.0e200), $realtobits(-1.0e200), a, a);
    chk(got_zl == 64'hfff0000000000000, "R8", "-inf", got_zl, 64'hfff0000000000000);
    run_op($realtobits(2.0), $realtobits(3.0), $realtobits(2.0), $realtobits(3.0));
    chk(got_zu == $realtobits(9.0), "R3", "normal after overflow", got_zu, $realtobits(9.0));
    chk(ovf == 1'b1 && unf == 1'b1, "R8", "flags sticky", {62'b0, ovf, unf}, 64'd3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule